// File: doc/BRIEF.md
# E-paper waveform table sequencer

This block plays back the drive waveform of an electrophoretic display from a 70-byte table that is loaded through a byte-wide write port. A waveform is built from seven groups. Each group has four phases, and each group is replayed a programmed number of times. Each phase holds one 2-bit voltage-level code on each of five channels for a programmed number of gate pulses. Four of the channels serve the pixel transitions black-to-black, black-to-white, white-to-black and white-to-white. The fifth serves the common electrode. A gate-pulse tick input paces playback, and the level outputs change only on the clock edge that samples a tick.

Software loads the table while the block is idle and then pulses `start`. It then supplies one tick per gate pulse until `done` fires. Phases with a zero length, and groups that have nothing to play, are passed over without using any tick. The ticks must be at least 16 clock cycles apart, which gives the search for the next playable phase time to finish.

The controller has the states IDLE, SEEK, READY, PLAY, TAIL and FIN. Its transitions are:
- start: IDLE to SEEK.
- found: SEEK to READY.
- exhausted: SEEK to TAIL, or to FIN when nothing was played.
- launch: READY to PLAY, or READY to SEEK for a one-pulse phase.
- phase end: PLAY to SEEK.
- final tick: TAIL to FIN.
- release: FIN to IDLE.

Top module: `epd_wave_seq`

## Requirements
- R1: A write with `tbl_we` high and `tbl_addr` below 70 stores `tbl_wdata`. The level byte for channel c and group g is at address c*7+g, with channels in the order 0 = BB, 1 = BW, 2 = WB, 3 = WW, 4 = VCOM. The timing byte k of group g is at address 35+g*5+k, where k = 0..3 gives the lengths of phases A..D and k = 4 gives the repeat count. Writes at address 70 or above are ignored.
- R2: Table writes while `busy` is high are ignored.
- R3: `start` is accepted only when the block is idle (`busy` and `done` both low). `busy` is high in the cycle after an accepted start. A start while busy has no effect.
- R4: When a phase begins, each channel outputs the 2-bit field of its level byte for that group. Phase A uses bits 7:6, phase B bits 5:4, phase C bits 3:2 and phase D bits 1:0. The codes are 00 VSS, 01 VSH1, 10 VSL and 11 VSH2.
- R5: A phase with length L outputs its level for exactly L ticks. A phase of length 0 is skipped and uses no tick.
- R6: Group n plays its A-B-C-D sequence as many times as its repeat count. A group with repeat count 0, or with all four lengths 0, is skipped without using any tick.
- R7: Groups are played in ascending order, 0 through 6.
- R8: The level outputs change only on a clock edge where `tick` is high. Ticks must be at least 16 cycles apart.
- R9: `busy` stays high until the tick that ends the last pulse. The cycle after that tick has `busy` low, `done` high for exactly one cycle, and all outputs at 00.
- R10: While idle, all level outputs are 00. A start with nothing playable in the table completes with a `done` pulse and no ticks.
- R11: Phase lengths and repeat counts are 8-bit values, and 255 is honoured for both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 7 | Table byte address |
| tbl_wdata | input | 8 | Table write data |
| start | input | 1 | Start playback strobe |
| tick | input | 1 | Gate-pulse tick |
| lvl_bb | output | 2 | Level code, black-to-black |
| lvl_bw | output | 2 | Level code, black-to-white |
| lvl_wb | output | 2 | Level code, white-to-black |
| lvl_ww | output | 2 | Level code, white-to-white |
| lvl_vcom | output | 2 | Level code, common electrode |
| busy | output | 1 | Playback in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- an accepted start raises `busy`;
- the levels never move without a tick;
- the outputs are VSS whenever the block is not busy;
- `done` is a single-cycle pulse that coincides with the fall of `busy`.

Only the bench's scenarios can show that the levels follow the table correctly. That covers the bit position of each phase, the exact count of ticks per phase, repeats and group order, and skipped phases and groups using no ticks. The scenarios also show that writes and starts issued during playback leave the played waveform untouched.

// File: rtl/epd_wave_pkg.sv
package epd_wave_pkg;

    localparam int N_CHAN  = 5;
    localparam int N_PHASE = 4;
    localparam int LVL_W   = 2;
    localparam int BYTE_W  = 8;
    localparam int PH_W    = $clog2(N_PHASE);

    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEEK,
        S_READY,
        S_PLAY,
        S_TAIL,
        S_FIN
    } seq_state_t;

    // phase 0 sits in the most significant field of a level byte
    function automatic lvl_t pick_level(input byte_t b, input logic [PH_W-1:0] ph);
        int base;
        base = (N_PHASE - 1 - int'(ph)) * LVL_W;
        pick_level = b[base +: LVL_W];
    endfunction

endpackage

// File: rtl/epd_wave_table.sv
module epd_wave_table
    import epd_wave_pkg::*;
#(
    parameter int N_GROUP = 7,
    parameter int ADDR_W  = 7,
    parameter int GRP_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  byte_t                     wdata,
    input  logic                      lock,
    input  logic [GRP_W-1:0]          rd_grp,
    output byte_t [N_CHAN-1:0]        lvl_row,
    output byte_t [N_PHASE:0]         tim_row
);

    localparam int LVL_BYTES  = N_CHAN * N_GROUP;
    localparam int TIM_STRIDE = N_PHASE + 1;
    localparam int DEPTH      = LVL_BYTES + N_GROUP * TIM_STRIDE;

    byte_t            mem [DEPTH];
    logic [GRP_W-1:0] grp_safe;
    logic             wr_ok;

    assign wr_ok    = we && !lock && (int'(addr) < DEPTH);
    assign grp_safe = (int'(rd_grp) < N_GROUP) ? rd_grp : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_ok) begin
            mem[addr] <= wdata;
        end
    end

    for (genvar c = 0; c < N_CHAN; c++) begin : g_lvl_rd
        assign lvl_row[c] = mem[ADDR_W'(c * N_GROUP) + ADDR_W'(grp_safe)];
    end

    for (genvar k = 0; k < TIM_STRIDE; k++) begin : g_tim_rd
        assign tim_row[k] = mem[ADDR_W'(LVL_BYTES + k) + ADDR_W'(grp_safe) * ADDR_W'(TIM_STRIDE)];
    end

endmodule

// File: rtl/epd_wave_ctrl.sv
module epd_wave_ctrl
    import epd_wave_pkg::*;
#(
    parameter int N_GROUP = 7,
    parameter int GRP_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               tick,
    input  byte_t [N_PHASE:0]  tim_row,
    output logic [GRP_W-1:0]   grp,
    output logic [PH_W-1:0]    ph,
    output logic               launch,
    output logic               clear,
    output logic               busy,
    output logic               done
);

    seq_state_t        state, state_n;
    logic [GRP_W-1:0]  grp_n, step_grp;
    logic [PH_W-1:0]   ph_n, step_ph;
    byte_t             rep, rep_n, step_rep;
    byte_t             rem, rem_n;
    logic              played, played_n;

    byte_t             tp_cur, rp_cur;
    logic              any_len, grp_empty, past_end;

    assign tp_cur   = tim_row[ph];
    assign rp_cur   = tim_row[N_PHASE];
    assign past_end = (grp == GRP_W'(N_GROUP));

    always_comb begin
        any_len = 1'b0;
        for (int p = 0; p < N_PHASE; p++) begin
            any_len = any_len | (tim_row[p] != '0);
        end
    end

    assign grp_empty = (rp_cur == '0) || !any_len;

    // pointer advance: phase, then repeat, then group
    always_comb begin
        step_grp = grp;
        step_ph  = ph;
        step_rep = rep;
        if (ph == PH_W'(N_PHASE - 1)) begin
            step_ph = '0;
            if (rep == rp_cur - 8'd1) begin
                step_grp = grp + 1'b1;
                step_rep = '0;
            end else begin
                step_rep = rep + 8'd1;
            end
        end else begin
            step_ph = ph + 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_n  = state;
        grp_n    = grp;
        ph_n     = ph;
        rep_n    = rep;
        rem_n    = rem;
        played_n = played;
        launch   = 1'b0;
        clear    = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    state_n  = S_SEEK;
                    grp_n    = '0;
                    ph_n     = '0;
                    rep_n    = '0;
                    played_n = 1'b0;
                end
            end
            S_SEEK: begin
                if (past_end) begin
                    state_n = played ? S_TAIL : S_FIN;
                end else if (grp_empty) begin
                    grp_n = grp + 1'b1;
                    ph_n  = '0;
                    rep_n = '0;
                end else if (tp_cur == '0) begin
                    grp_n = step_grp;
                    ph_n  = step_ph;
                    rep_n = step_rep;
                end else begin
                    state_n = S_READY;
                end
            end
            S_READY: begin
                if (tick) begin
                    launch   = 1'b1;
                    played_n = 1'b1;
                    rem_n    = tp_cur - 8'd1;
                    if (tp_cur == 8'd1) begin
                        grp_n   = step_grp;
                        ph_n    = step_ph;
                        rep_n   = step_rep;
                        state_n = S_SEEK;
                    end else begin
                        state_n = S_PLAY;
                    end
                end
            end
            S_PLAY: begin
                if (tick) begin
                    rem_n = rem - 8'd1;
                    if (rem == 8'd1) begin
                        grp_n   = step_grp;
                        ph_n    = step_ph;
                        rep_n   = step_rep;
                        state_n = S_SEEK;
                    end
                end
            end
            S_TAIL: begin
                if (tick) begin
                    clear   = 1'b1;
                    state_n = S_FIN;
                end
            end
            S_FIN: begin
                state_n = S_IDLE;
            end
            default: begin
                state_n = S_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            grp    <= '0;
            ph     <= '0;
            rep    <= '0;
            rem    <= '0;
            played <= 1'b0;
        end else begin
            state  <= state_n;
            grp    <= grp_n;
            ph     <= ph_n;
            rep    <= rep_n;
            rem    <= rem_n;
            played <= played_n;
        end
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            S_IDLE:                          ;
            S_SEEK, S_READY, S_PLAY, S_TAIL: busy = 1'b1;
            S_FIN:                           done = 1'b1;
            default:                         ;
        endcase
    end

endmodule

// File: rtl/epd_wave_level.sv
module epd_wave_level
    import epd_wave_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              clear,
    input  logic [PH_W-1:0]   ph,
    input  byte_t [N_CHAN-1:0] lvl_row,
    output lvl_t [N_CHAN-1:0] lvl_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (clear) begin
            lvl_q <= '0;
        end else if (launch) begin
            for (int c = 0; c < N_CHAN; c++) begin
                lvl_q[c] <= pick_level(lvl_row[c], ph);
            end
        end
    end

endmodule

// File: rtl/epd_wave_seq.sv
module epd_wave_seq
    import epd_wave_pkg::*;
#(
    parameter int N_GROUP = 7,
    parameter int ADDR_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [7:0]        tbl_wdata,
    input  logic              start,
    input  logic              tick,
    output logic [1:0]        lvl_bb,
    output logic [1:0]        lvl_bw,
    output logic [1:0]        lvl_wb,
    output logic [1:0]        lvl_ww,
    output logic [1:0]        lvl_vcom,
    output logic              busy,
    output logic              done
);

    localparam int GRP_W = $clog2(N_GROUP + 1);

    logic [GRP_W-1:0]    grp;
    logic [PH_W-1:0]     ph;
    logic                launch, clear;
    byte_t [N_CHAN-1:0]  lvl_row;
    byte_t [N_PHASE:0]   tim_row;
    lvl_t  [N_CHAN-1:0]  lvl_q;

    epd_wave_table #(
        .N_GROUP (N_GROUP),
        .ADDR_W  (ADDR_W),
        .GRP_W   (GRP_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (tbl_we),
        .addr    (tbl_addr),
        .wdata   (tbl_wdata),
        .lock    (busy),
        .rd_grp  (grp),
        .lvl_row (lvl_row),
        .tim_row (tim_row)
    );

    epd_wave_ctrl #(
        .N_GROUP (N_GROUP),
        .GRP_W   (GRP_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tick    (tick),
        .tim_row (tim_row),
        .grp     (grp),
        .ph      (ph),
        .launch  (launch),
        .clear   (clear),
        .busy    (busy),
        .done    (done)
    );

    epd_wave_level u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .clear   (clear),
        .ph      (ph),
        .lvl_row (lvl_row),
        .lvl_q   (lvl_q)
    );

    assign lvl_bb   = lvl_q[0];
    assign lvl_bw   = lvl_q[1];
    assign lvl_wb   = lvl_q[2];
    assign lvl_ww   = lvl_q[3];
    assign lvl_vcom = lvl_q[4];

endmodule

// File: rtl/epd_wave_seq_chk.sv
module epd_wave_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       tick,
    input logic [1:0] lvl_bb,
    input logic [1:0] lvl_bw,
    input logic [1:0] lvl_wb,
    input logic [1:0] lvl_ww,
    input logic [1:0] lvl_vcom,
    input logic       busy,
    input logic       done
);

    logic [9:0] lv;
    assign lv = {lvl_bb, lvl_bw, lvl_wb, lvl_ww, lvl_vcom};

    p_busy_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start) |=> busy);

    p_lvl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(lv));

    p_idle_vss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lv == 10'd0));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_busy_fall_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

bind epd_wave_seq epd_wave_seq_chk u_chk (.*);

// File: tb/epd_wave_seq_tb.sv
`timescale 1ns/1ps
module epd_wave_seq_tb;

    localparam int GAP = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tbl_we = 1'b0;
    logic [6:0] tbl_addr = '0;
    logic [7:0] tbl_wdata = '0;
    logic       start = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] lvl_bb, lvl_bw, lvl_wb, lvl_ww, lvl_vcom;
    logic       busy, done;

    int total = 0;
    int bad = 0;

    logic [7:0] tb_tbl [0:69];
    logic [9:0] exp_a [0:2047];
    int         exp_n;

    always #4 clk = ~clk;

    epd_wave_seq u_dut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .start(start), .tick(tick),
        .lvl_bb(lvl_bb), .lvl_bw(lvl_bw), .lvl_wb(lvl_wb), .lvl_ww(lvl_ww),
        .lvl_vcom(lvl_vcom), .busy(busy), .done(done)
    );

    function automatic logic [9:0] cur_lv();
        return {lvl_bb, lvl_bw, lvl_wb, lvl_ww, lvl_vcom};
    endfunction

    task automatic chk(input string tag, input int act, input int expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 7'(a); tbl_wdata = 8'(d);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic load_all();
        for (int a = 0; a < 70; a++) wr(a, int'(tb_tbl[a]));
    endtask

    task automatic clear_model();
        for (int a = 0; a < 70; a++) tb_tbl[a] = 8'h00;
    endtask

    // expected level word for every pulse, nested group / repeat / phase
    task automatic build_exp();
        exp_n = 0;
        for (int g = 0; g < 7; g++) begin
            for (int r = 0; r < int'(tb_tbl[35 + g*5 + 4]); r++) begin
                for (int p = 0; p < 4; p++) begin
                    for (int k = 0; k < int'(tb_tbl[35 + g*5 + p]); k++) begin
                        logic [9:0] v;
                        v = '0;
                        for (int c = 0; c < 5; c++) begin
                            v = {v[7:0], 2'((tb_tbl[c*7 + g] >> (6 - 2*p)) & 8'h3)};
                        end
                        exp_a[exp_n] = v;
                        exp_n++;
                    end
                end
            end
        end
    endtask

    task automatic run_seq(input string tag, input bit poke);
        logic [9:0] prev;
        build_exp();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk({tag, " R3 busy after start"}, int'(busy), 1);
        if (exp_n == 0) begin
            for (int k = 0; k < 40; k++) begin
                if (done) break;
                @(negedge clk);
            end
            chk({tag, " R10 empty run done"}, int'(done), 1);
            chk({tag, " R10 empty run levels"}, int'(cur_lv()), 0);
            @(negedge clk);
            return;
        end
        if (poke) begin
            for (int a = 0; a < 70; a++) wr(a, int'(~tb_tbl[a]));
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        repeat (GAP) @(negedge clk);
        prev = '0;
        for (int i = 0; i < exp_n; i++) begin
            chk({tag, " R8 hold between ticks"}, int'(cur_lv()), int'(prev));
            tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            chk({tag, " R5 level on tick"}, int'(cur_lv()), int'(exp_a[i]));
            prev = exp_a[i];
            repeat (GAP - 1) @(negedge clk);
        end
        chk({tag, " R9 busy before final tick"}, int'(busy), 1);
        chk({tag, " R9 no early done"}, int'(done), 0);
        tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk({tag, " R9 done pulse"}, int'(done), 1);
        chk({tag, " R9 busy low"}, int'(busy), 0);
        chk({tag, " R9 levels cleared"}, int'(cur_lv()), 0);
        @(negedge clk);
        chk({tag, " R9 done single"}, int'(done), 0);
        chk({tag, " R3 no restart"}, int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset busy", int'(busy), 0);
        chk("R10 reset done", int'(done), 0);
        chk("R10 reset levels", int'(cur_lv()), 0);

        // two-phase groups replayed twice (R6)
        clear_model();
        tb_tbl[0] = 8'h80; tb_tbl[1] = 8'h60; tb_tbl[2] = 8'h40;
        tb_tbl[7] = 8'h10; tb_tbl[8] = 8'h60; tb_tbl[9] = 8'h20;
        tb_tbl[14] = 8'h80; tb_tbl[15] = 8'h60; tb_tbl[16] = 8'h40;
        tb_tbl[21] = 8'h10; tb_tbl[22] = 8'h60; tb_tbl[23] = 8'h20;
        tb_tbl[35] = 3; tb_tbl[36] = 3; tb_tbl[39] = 2;
        tb_tbl[40] = 9; tb_tbl[41] = 9; tb_tbl[44] = 2;
        tb_tbl[45] = 3; tb_tbl[46] = 3; tb_tbl[49] = 2;
        load_all();
        run_seq("R6 repeated pairs", 1'b0);

        // single long phase, plus writes and start during playback (R2)
        clear_model();
        tb_tbl[7] = 8'h80; tb_tbl[14] = 8'h40; tb_tbl[21] = 8'h80;
        tb_tbl[35] = 8'h0A; tb_tbl[39] = 4;
        load_all();
        run_seq("R2 locked table", 1'b1);
        run_seq("R2 table intact", 1'b0);

        // each phase position alone, bit field sweep (R4)
        for (int p = 0; p < 4; p++) begin
            clear_model();
            tb_tbl[0*7 + p + 1] = 8'h1B; tb_tbl[1*7 + p + 1] = 8'hE4;
            tb_tbl[2*7 + p + 1] = 8'h4E; tb_tbl[3*7 + p + 1] = 8'hB1;
            tb_tbl[4*7 + p + 1] = 8'h93;
            tb_tbl[35 + (p+1)*5 + p] = 8'(p + 1);
            tb_tbl[35 + (p+1)*5 + 4] = 1;
            load_all();
            run_seq("R4 phase field", 1'b0);
        end

        // arithmetic sweep, zero phases and empty groups (R7)
        clear_model();
        for (int g = 0; g < 7; g++) begin
            for (int c = 0; c < 5; c++) tb_tbl[c*7 + g] = 8'((c*53 + g*29 + 17) & 255);
            for (int p = 0; p < 4; p++) tb_tbl[35 + g*5 + p] = 8'((g*3 + p*5) % 4);
            tb_tbl[35 + g*5 + 4] = 8'(g % 3);
        end
        tb_tbl[35 + 4*5 + 0] = 0; tb_tbl[35 + 4*5 + 1] = 0;
        tb_tbl[35 + 4*5 + 2] = 0; tb_tbl[35 + 4*5 + 3] = 0;
        load_all();
        // out-of-range writes must not land anywhere (R1)
        for (int a = 70; a < 128; a++) wr(a, 8'hFF);
        run_seq("R7 group sweep R1", 1'b0);

        // empty table (R10)
        clear_model();
        load_all();
        run_seq("R10 empty", 1'b0);

        // 8-bit limits (R11)
        clear_model();
        tb_tbl[6] = 8'hC0; tb_tbl[34] = 8'h40;
        tb_tbl[35 + 6*5 + 0] = 255; tb_tbl[35 + 6*5 + 4] = 1;
        load_all();
        run_seq("R11 length 255", 1'b0);

        clear_model();
        tb_tbl[13] = 8'h0C; tb_tbl[27] = 8'h08;
        tb_tbl[35 + 6*5 + 2] = 1; tb_tbl[35 + 6*5 + 4] = 255;
        load_all();
        run_seq("R11 repeat 255", 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule